// File: doc/BRIEF.md
# Virtual Interrupt List Register Bank

This block keeps a small bank of list-register entries for a virtual CPU interface. Each entry describes one virtual interrupt: a two-bit lifecycle state, a flag saying whether the interrupt is backed by a physical one, a group bit, a priority, and a 13-bit field that holds either a physical interrupt ID or, for purely virtual interrupts, an end-of-interrupt notification flag. A host port loads and reads back entries as 32-bit words.

A lifecycle port lets the virtual CPU acknowledge an entry or deactivate it. Deactivating an active entry forwards a deactivate request with the stored physical ID when the entry is hardware-backed. Otherwise it raises a one-cycle maintenance pulse if the entry asked for one. From the pending entries, the bank drives registered virtual IRQ and FIQ request lines. The entry with the numerically lowest priority value among the enabled pending entries decides which line is raised.

Top module: `vlr_bank`

## Requirements
- R1: A synchronous reset clears every entry to all zeros (state invalid) and drives vint_irq, vint_fiq, dir_valid, dir_pintid and eoi_maint to zero.
- R2: A host write to an implemented index stores the word. Its fields are state in bits 31:30 (00 invalid, 01 pending, 10 active, 11 pending and active), hardware flag in bit 29, group in bit 28, priority in bits 23:16 and low field in bits 12:0. Reading back gives the same layout, and bits 27:24 and 15:13 always read as zero.
- R3: Only the top PRIO_BITS bits of the priority byte are kept; the remaining low priority bits read as zero (with PRIO_BITS=5, bits 18:16 read zero).
- R4: When the stored hardware flag is 0, only bit 9 of the low field reads back; bits 12:10 and 8:0 read as zero. When the flag is 1, all 13 bits read back.
- R5: A write to an index at or above N_ENTRIES changes nothing, a read of such an index returns zero, and a lifecycle request to such an index changes no entry and raises no pulse.
- R6: An acknowledge moves state 01 or 11 to 10 and leaves states 00 and 10 unchanged.
- R7: A deactivate clears the active bit (10 to 00, 11 to 01). If the entry was active and its hardware flag is 1, dir_valid pulses for one cycle on the cycle after the request, with dir_pintid equal to the stored low field. If it was active, the flag is 0 and low bit 9 is 1, eoi_maint pulses instead. An entry that was not active raises neither pulse.
- R8: A group 0 entry signals on vint_fiq when fiq_en is 1 and on vint_irq otherwise, and only while grp0_en is 1. A group 1 entry signals only on vint_irq, and only while grp1_en is 1.
- R9: Among the entries whose pending bit (state bit 0) is set and whose group is enabled, the one with the lowest priority value drives the lines, with ties going to the lowest index. Entries in states 00 and 10 never signal. The lines are registered and follow a change of state or enable one clock later.
- R10: When a host write and a lifecycle request hit the same index in the same cycle, the write takes effect and the lifecycle request is dropped with no pulse.
- R11: rd_data presents the entry selected by rd_idx one clock after rd_idx is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_idx | input | 4 | Host write entry index |
| wr_data | input | 32 | Host write word |
| rd_idx | input | 4 | Host read entry index |
| rd_data | output | 32 | Registered read word |
| lc_valid | input | 1 | Lifecycle request strobe, one cycle |
| lc_op | input | 1 | 0 acknowledge, 1 deactivate |
| lc_idx | input | 4 | Lifecycle entry index |
| grp0_en | input | 1 | Group 0 signalling enable |
| grp1_en | input | 1 | Group 1 signalling enable |
| fiq_en | input | 1 | Route group 0 to FIQ |
| vint_irq | output | 1 | Virtual IRQ request |
| vint_fiq | output | 1 | Virtual FIQ request |
| dir_valid | output | 1 | Physical deactivate request pulse |
| dir_pintid | output | 13 | Physical ID carried with the request |
| eoi_maint | output | 1 | EOI maintenance pulse |

## Verification
The host write and the lifecycle request can land on the same entry in the same cycle. The bench provokes this by deactivating an active hardware-backed entry while rewriting it with a pending word. It judges the result by the absence of dir_valid on the next cycle and by a read back that returns the new word. The second overlap is between lifecycle changes and the request lines. After every state change, the IRQ/FIQ pair is swept over all eight enable combinations and compared with a lowest-priority search made in the bench.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
  localparam int WORD_W  = 32;
  localparam int LOW_W   = 13;
  localparam int IDX_W   = 4;
  localparam int EOI_BIT = 9;

  typedef enum logic [1:0] {
    ST_INV  = 2'b00,
    ST_PEND = 2'b01,
    ST_ACT  = 2'b10,
    ST_PACT = 2'b11
  } lr_state_e;

  typedef enum logic {
    OP_ACK   = 1'b0,
    OP_DEACT = 1'b1
  } lc_op_e;

  typedef struct packed {
    lr_state_e        st;
    logic             hw;
    logic             grp;
    logic [7:0]       prio;
    logic [LOW_W-1:0] low;
  } lr_entry_t;
endpackage

// File: rtl/vlr_entry.sv
module vlr_entry
  import vlr_pkg::*;
#(
  parameter int PRIO_BITS = 5
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_hit,
  input  lr_entry_t wr_ent,
  input  logic      lc_hit,
  input  lc_op_e    lc_op,
  output lr_entry_t ent
);
  localparam logic [7:0] PRIO_MASK = 8'hFF << (8 - PRIO_BITS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent <= '0;
    end else if (wr_hit) begin
      ent.st   <= wr_ent.st;
      ent.hw   <= wr_ent.hw;
      ent.grp  <= wr_ent.grp;
      ent.prio <= wr_ent.prio & PRIO_MASK;
      ent.low  <= wr_ent.low;
    end else if (lc_hit) begin
      if (lc_op == OP_ACK) begin
        if (ent.st[0]) ent.st <= ST_ACT;
      end else begin
        ent.st <= lr_state_e'({1'b0, ent.st[0]});
      end
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk) rst |=> ent == '0);
  a_r6_ack_to_active: assert property (@(posedge clk) disable iff (rst)
    (lc_hit && !wr_hit && lc_op == OP_ACK && ent.st[0]) |=> ent.st == ST_ACT);
  a_r7_deact_clears_active: assert property (@(posedge clk) disable iff (rst)
    (lc_hit && !wr_hit && lc_op == OP_DEACT) |=> !ent.st[1]);
  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (ent.st == $past(wr_ent.st)) && (ent.hw == $past(wr_ent.hw)));
endmodule

// File: rtl/vlr_select.sv
module vlr_select
  import vlr_pkg::*;
#(
  parameter int N_ENTRIES = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  lr_entry_t ents [N_ENTRIES],
  input  logic      grp0_en,
  input  logic      grp1_en,
  input  logic      fiq_en,
  output logic      vint_irq,
  output logic      vint_fiq
);
  logic       found;
  logic [7:0] best_prio;
  logic       best_grp;
  logic       any_pend;

  always_comb begin
    found     = 1'b0;
    best_prio = '1;
    best_grp  = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (ents[i].st[0] && (ents[i].grp ? grp1_en : grp0_en) &&
          (!found || ents[i].prio < best_prio)) begin
        found     = 1'b1;
        best_prio = ents[i].prio;
        best_grp  = ents[i].grp;
      end
    end
  end

  always_comb begin
    any_pend = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) any_pend = any_pend | ents[i].st[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vint_irq <= 1'b0;
      vint_fiq <= 1'b0;
    end else begin
      vint_irq <= found && (best_grp || !fiq_en);
      vint_fiq <= found && !best_grp && fiq_en;
    end
  end

  a_r8_one_line: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vint_irq, vint_fiq}));
  a_r9_quiet_without_pending: assert property (@(posedge clk) disable iff (rst)
    !any_pend |=> !(vint_irq || vint_fiq));
endmodule

// File: rtl/vlr_deact.sv
module vlr_deact
  import vlr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             lc_fire,
  input  lc_op_e           lc_op,
  input  lr_entry_t        sel,
  output logic             dir_valid,
  output logic [LOW_W-1:0] dir_pintid,
  output logic             eoi_maint
);
  logic retire;
  assign retire = lc_fire && (lc_op == OP_DEACT) && sel.st[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_valid  <= 1'b0;
      dir_pintid <= '0;
      eoi_maint  <= 1'b0;
    end else begin
      dir_valid  <= retire && sel.hw;
      dir_pintid <= (retire && sel.hw) ? sel.low : '0;
      eoi_maint  <= retire && !sel.hw && sel.low[EOI_BIT];
    end
  end

  a_r7_paths_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dir_valid && eoi_maint));
  a_r7_pulse_has_cause: assert property (@(posedge clk) disable iff (rst)
    (dir_valid || eoi_maint) |-> $past(lc_fire && lc_op == OP_DEACT));
endmodule

// File: rtl/vlr_bank.sv
module vlr_bank
  import vlr_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int PRIO_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  input  logic              lc_valid,
  input  logic              lc_op,
  input  logic [IDX_W-1:0]  lc_idx,
  input  logic              grp0_en,
  input  logic              grp1_en,
  input  logic              fiq_en,
  output logic              vint_irq,
  output logic              vint_fiq,
  output logic              dir_valid,
  output logic [LOW_W-1:0]  dir_pintid,
  output logic              eoi_maint
);
  localparam logic [LOW_W-1:0] EOI_MASK = LOW_W'(1) << EOI_BIT;

  lr_entry_t ents [N_ENTRIES];
  lr_entry_t wr_ent;
  lr_entry_t lc_sel;
  logic      wr_ok, lc_ok, collide, lc_fire;
  logic [WORD_W-1:0] rd_word;
  logic      unused_rsvd;

  assign unused_rsvd = ^{wr_data[27:24], wr_data[15:13]};

  assign wr_ent.st   = lr_state_e'(wr_data[31:30]);
  assign wr_ent.hw   = wr_data[29];
  assign wr_ent.grp  = wr_data[28];
  assign wr_ent.prio = wr_data[23:16];
  assign wr_ent.low  = wr_data[12:0];

  assign wr_ok   = wr_en && (32'(wr_idx) < N_ENTRIES);
  assign lc_ok   = lc_valid && (32'(lc_idx) < N_ENTRIES);
  assign collide = wr_ok && (wr_idx == lc_idx);
  assign lc_fire = lc_ok && !collide;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    vlr_entry #(.PRIO_BITS(PRIO_BITS)) ent_i (
      .clk    (clk),
      .rst    (rst),
      .wr_hit (wr_ok && (32'(wr_idx) == g)),
      .wr_ent (wr_ent),
      .lc_hit (lc_fire && (32'(lc_idx) == g)),
      .lc_op  (lc_op_e'(lc_op)),
      .ent    (ents[g])
    );
  end

  function automatic logic [WORD_W-1:0] pack_word(input lr_entry_t e);
    logic [LOW_W-1:0] low_vis;
    low_vis = e.hw ? e.low : (e.low & EOI_MASK);
    return {e.st, e.hw, e.grp, 4'b0, e.prio, 3'b0, low_vis};
  endfunction

  always_comb begin
    rd_word = '0;
    lc_sel  = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (32'(rd_idx) == i) rd_word = pack_word(ents[i]);
      if (32'(lc_idx) == i) lc_sel = ents[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_word;
  end

  vlr_select #(.N_ENTRIES(N_ENTRIES)) sel_i (
    .clk      (clk),
    .rst      (rst),
    .ents     (ents),
    .grp0_en  (grp0_en),
    .grp1_en  (grp1_en),
    .fiq_en   (fiq_en),
    .vint_irq (vint_irq),
    .vint_fiq (vint_fiq)
  );

  vlr_deact deact_i (
    .clk        (clk),
    .rst        (rst),
    .lc_fire    (lc_fire),
    .lc_op      (lc_op_e'(lc_op)),
    .sel        (lc_sel),
    .dir_valid  (dir_valid),
    .dir_pintid (dir_pintid),
    .eoi_maint  (eoi_maint)
  );

  a_r5_no_pulse_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (lc_valid && !lc_ok) |=> !(dir_valid || eoi_maint));
  a_r10_collision_silent: assert property (@(posedge clk) disable iff (rst)
    collide |=> !(dir_valid || eoi_maint));
endmodule

// File: tb/vlr_bank_tb_top.sv
`timescale 1ns/1ps
module vlr_bank_tb_top;
  localparam int N  = 4;
  localparam int PB = 5;
  localparam logic [7:0] PMASK = 8'hFF << (8 - PB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, lc_valid = 0, lc_op = 0;
  logic [3:0] wr_idx = 0, rd_idx = 0, lc_idx = 0;
  logic [31:0] wr_data = 0;
  logic grp0_en = 0, grp1_en = 0, fiq_en = 0;
  logic [31:0] rd_data;
  logic vint_irq, vint_fiq, dir_valid, eoi_maint;
  logic [12:0] dir_pintid;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  logic [1:0]  m_st   [16];
  logic        m_hw   [16];
  logic        m_grp  [16];
  logic [7:0]  m_prio [16];
  logic [12:0] m_low  [16];

  always #10 clk = ~clk;

  vlr_bank #(.N_ENTRIES(N), .PRIO_BITS(PB)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .lc_valid(lc_valid), .lc_op(lc_op),
    .lc_idx(lc_idx), .grp0_en(grp0_en), .grp1_en(grp1_en), .fiq_en(fiq_en),
    .vint_irq(vint_irq), .vint_fiq(vint_fiq), .dir_valid(dir_valid),
    .dir_pintid(dir_pintid), .eoi_maint(eoi_maint)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int i);
    if (i >= N) return 32'h0;
    return {m_st[i], m_hw[i], m_grp[i], 4'b0, m_prio[i], 3'b0,
            m_hw[i] ? m_low[i] : (m_low[i] & 13'h0200)};
  endfunction

  function automatic logic [1:0] exp_lines(input bit g0, input bit g1, input bit fe);
    bit found = 0;
    logic [7:0] bp = 8'hFF;
    bit bg = 0;
    for (int i = 0; i < N; i++)
      if (m_st[i][0] && (m_grp[i] ? g1 : g0) && (!found || m_prio[i] < bp)) begin
        found = 1; bp = m_prio[i]; bg = m_grp[i];
      end
    if (!found) return 2'b00;
    return (bg || !fe) ? 2'b01 : 2'b10;
  endfunction

  task automatic model_write(input int idx, input logic [31:0] d);
    if (idx < N) begin
      m_st[idx] = d[31:30]; m_hw[idx] = d[29]; m_grp[idx] = d[28];
      m_prio[idx] = d[23:16] & PMASK; m_low[idx] = d[12:0];
    end
  endtask

  task automatic do_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_write(idx, d);
  endtask

  task automatic chk_read(input int idx, input string req);
    @(negedge clk);
    rd_idx = 4'(idx);
    @(negedge clk);
    chk(req, rd_data, exp_word(idx));
  endtask

  task automatic do_lc(input bit op, input int idx, input string req);
    logic [31:0] exp;
    bit act, dv, ev;
    act = (idx < N) && m_st[idx][1];
    dv  = op && act && m_hw[idx];
    ev  = op && act && !m_hw[idx] && m_low[idx][9];
    exp = {dv, ev, 17'b0, dv ? m_low[idx] : 13'h0};
    @(negedge clk);
    lc_valid = 1; lc_op = op; lc_idx = 4'(idx);
    @(negedge clk);
    lc_valid = 0;
    chk(req, {dir_valid, eoi_maint, 17'b0, dir_pintid}, exp);
    if (idx < N) begin
      if (!op && m_st[idx][0]) m_st[idx] = 2'b10;
      if (op) m_st[idx] = {1'b0, m_st[idx][0]};
    end
  endtask

  task automatic sweep_lines(input string req);
    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      grp0_en = e[0]; grp1_en = e[1]; fiq_en = e[2];
      @(negedge clk);
      @(negedge clk);
      chk(req, {30'b0, vint_fiq, vint_irq}, {30'b0, exp_lines(e[0], e[1], e[2])});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_st[i] = 0; m_hw[i] = 0; m_grp[i] = 0; m_prio[i] = 0; m_low[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 outputs", {28'b0, vint_irq, vint_fiq, dir_valid, eoi_maint}, 32'h0);
    chk("R1 pintid", {19'b0, dir_pintid}, 32'h0);
    for (int i = 0; i < 16; i++) chk_read(i, "R1 entry");

    // R2 R5 R11: write / read-back sweep over all indices
    for (int i = 0; i < 16; i++)
      for (int k = 0; k < 4; k++) begin
        logic [31:0] d;
        d = 32'h9E3779B9 * (i * 4 + k + 1);
        if (k == 3) d = ~d;
        do_write(i, d);
        chk_read(i, (i < N) ? "R2 readback" : "R5 oob read");
        chk_read(i % N, "R5 neighbours intact");
      end

    // R3: priority low bits, hw set shows full low field
    do_write(0, 32'hFFFF_FFFF);
    chk_read(0, "R3 sweep");
    @(negedge clk); rd_idx = 0; @(negedge clk);
    chk("R3 literal", rd_data, 32'hF0F8_1FFF);
    // R4: hw clear hides all but bit 9
    do_write(1, 32'hDFFF_FFFF);
    @(negedge clk); rd_idx = 1; @(negedge clk);
    chk("R4 literal", rd_data, 32'hD0F8_0200);

    // R6 R7: lifecycle sweep
    for (int i = 0; i < N; i++)
      for (int s = 0; s < 4; s++)
        for (int op = 0; op < 2; op++)
          for (int h = 0; h < 2; h++) begin
            logic [12:0] low;
            logic [31:0] d;
            low = h ? 13'(13'h1000 | (i * 37 + s)) : ((s + op) % 2 ? 13'h0200 : 13'h01FF);
            d = {2'(s), 1'(h), 1'(i), 4'b0, 8'(i * 40 + s), 3'b0, low};
            do_write(i, d);
            do_lc(op[0], i, op ? "R7 deactivate" : "R6 acknowledge");
            chk_read(i, op ? "R7 state" : "R6 state");
          end

    // R5: lifecycle out of range
    do_write(2, 32'hA000_1234);
    do_lc(1'b1, 9, "R5 oob lifecycle");
    chk_read(2, "R5 entry untouched");

    // R10: write and deactivate on the same entry in one cycle
    do_write(3, 32'hA000_0ABC);
    @(negedge clk);
    wr_en = 1; wr_idx = 3; wr_data = 32'h6055_0ABC;
    lc_valid = 1; lc_op = 1; lc_idx = 3;
    @(negedge clk);
    wr_en = 0; lc_valid = 0;
    model_write(3, 32'h6055_0ABC);
    chk("R10 no pulse", {30'b0, dir_valid, eoi_maint}, 32'h0);
    chk_read(3, "R10 write wins");

    // R8 R9: arbitration sweep
    for (int t = 0; t < 64; t++) begin
      for (int i = 0; i < N; i++)
        do_write(i, {2'((t * 7 + i * 3) % 4), 1'b0, 1'((t >> i) & 1), 4'b0,
                     8'((t * 13 + i * 29) % 256), 16'h0});
      sweep_lines((t % 2) ? "R8 routing" : "R9 lowest priority");
    end

    // R9: tie goes to lowest index
    do_write(0, 32'h0000_0000);
    do_write(1, 32'h5040_0000);
    do_write(2, 32'h4040_0000);
    do_write(3, 32'h8000_0000);
    @(negedge clk); grp0_en = 1; grp1_en = 1; fiq_en = 1;
    @(negedge clk); @(negedge clk);
    chk("R9 tie", {30'b0, vint_fiq, vint_irq}, 32'h1);
    // R9: acknowledge the winner, group 0 entry takes over on FIQ
    do_lc(1'b0, 1, "R6 ack winner");
    @(negedge clk); @(negedge clk);
    chk("R9 after ack", {30'b0, vint_fiq, vint_irq}, 32'h2);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule